// File: doc/BRIEF.md
# Binary Motion Search Scan Sequencer and Best-Vector Tracker

This block drives an exhaustive block-matching search on one-bit pixel planes. It searches four neighbouring 16x16 macroblocks in lockstep over one shared search window. Each block has a displacement range of -16..+16 in both axes, which gives 33 candidate lines of 33 positions, or 1089 candidates per block.

The sequencer walks the candidate lines from top to bottom. For each line it issues two load strobes and then 32 shift strobes, each shift strobe carrying a column select. Alongside the strobes it drives a vertical rotate amount and a pair of read addresses for each of the eight banks of the window memory. Every bank stores two window lines per 16-line region in three 32-pixel column chunks.

A separate tracker consumes the mismatch counts that the matching arrays return. It takes one packed word of four counts per accepted strobe, in scan order. For each block it keeps the lowest count and the displacement that produced it. When the last candidate has been compared it raises a one-cycle done pulse.

The count input is a valid/ready stream with these rules:
- `cnt_ready` rises in the cycle after an accepted start and then stays high, with no back-pressure, until 1089 words have been taken.
- A word is taken on a rising edge where `cnt_valid` and `cnt_ready` are both high.
- A word offered while `cnt_ready` is low is dropped, and the producer need not hold it.

Top module: `fsme_scan_ctrl`

## Requirements
- R1: After reset, every output of the block is low or zero.
- R2: A `start` pulse takes effect only when the sequencer is idle and the tracker is not waiting for counts; otherwise it is ignored. The first load strobe appears in the cycle after the edge that samples `start`.
- R3: A scan is 33 lines of 34 cycles each, with `busy` high for exactly 1122 cycles. Each line consists of:
  - one `load_hi` cycle;
  - one `load_lo` cycle;
  - 32 `shift_en` cycles with `bit_sel` counting 0 to 31.

  At most one of the three strobes is high at a time. `bit_sel` is 0 outside shift cycles.
- R4: `rot_amt` equals the line index modulo 16 while busy, and is 0 when idle.
- R5: The column chunk is 0 in the `load_hi` cycle, 1 in the `load_lo` cycle and 2 in shift cycles. For candidate line L, the window lines are L to L+15. Window line s lives in bank (s mod 16)/2 at address (s/16)*6 + chunk*2 + (s mod 2). Bank b (bits [b*5 +: 5]) outputs the lower of its two addresses on `rd_addr_a` and the higher on `rd_addr_b`. Both are 0 when idle.
- R6: The count stream follows the ready rules stated above, and exactly 1089 words are taken per search. Block i's count occupies bits [i*9 +: 9] of `cnt_data`.
- R7: The k-th taken word (k from 0) belongs to displacement dy = k/33 - 16 and dx = 16 - (k mod 33). Both are 6-bit two's complement; block i's values occupy bits [i*6 +: 6].
- R8: Each block independently keeps the lowest count seen since the start. The first word always loads. On a tie the earlier candidate is retained. The running best is visible in the cycle after each taken word.
- R9: `done` is high for exactly one cycle, the cycle after the 1089th word is taken. At that point the best outputs hold the final results, and they stay stable until the next start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to begin a search |
| busy | output | 1 | Scan sequence in progress |
| load_hi | output | 1 | First line-load cycle (upper arrays) |
| load_lo | output | 1 | Second line-load cycle (lower arrays) |
| shift_en | output | 1 | Streaming shift cycle |
| bit_sel | output | 5 | Column select during streaming |
| rot_amt | output | 4 | Vertical rotate amount |
| rd_addr_a | output | 40 | Lower read address per bank, 5 bits each |
| rd_addr_b | output | 40 | Higher read address per bank, 5 bits each |
| cnt_valid | input | 1 | Count word valid |
| cnt_ready | output | 1 | Count word accepted when high |
| cnt_data | input | 36 | Four 9-bit mismatch counts |
| done | output | 1 | One-cycle completion pulse |
| best_dx | output | 24 | Four 6-bit horizontal displacements |
| best_dy | output | 24 | Four 6-bit vertical displacements |
| best_cost | output | 36 | Four 9-bit lowest counts |

## Verification
The strobes, rotate amount and addresses are all functions of registered scan state. They therefore change only in the cycle after a clock edge, so the first load strobe falls one cycle after the edge that samples `start`. A taken count word shows in the best outputs one cycle after the edge that takes it, and `done` follows the 1089th word by the same single cycle. The bench holds a behavioural model that it advances on each rising edge, so it expects every result in the cycle after its cause. It compares every output at the following falling edge, never at an edge.

// File: rtl/fsme_pkg.sv
package fsme_pkg;
  typedef enum logic [1:0] {
    PK_IDLE    = 2'd0,
    PK_LOAD_HI = 2'd1,
    PK_LOAD_LO = 2'd2,
    PK_STREAM  = 2'd3
  } phase_kind_e;
endpackage

// File: rtl/fsme_seq.sv
module fsme_seq
  import fsme_pkg::*;
#(
  parameter int LINES    = 33,
  parameter int LINE_CYC = 34,
  parameter int LW       = 6,
  parameter int PW       = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  output logic          busy,
  output logic [LW-1:0] line,
  output logic [PW-1:0] phase,
  output phase_kind_e   kind
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      line  <= '0;
      phase <= '0;
    end else if (go && !busy) begin
      busy  <= 1'b1;
      line  <= '0;
      phase <= '0;
    end else if (busy) begin
      if (phase == PW'(LINE_CYC - 1)) begin
        phase <= '0;
        if (line == LW'(LINES - 1)) begin
          busy <= 1'b0;
          line <= '0;
        end else begin
          line <= line + 1'b1;
        end
      end else begin
        phase <= phase + 1'b1;
      end
    end
  end

  always_comb begin
    if (!busy)                kind = PK_IDLE;
    else if (phase == '0)     kind = PK_LOAD_HI;
    else if (phase == PW'(1)) kind = PK_LOAD_LO;
    else                      kind = PK_STREAM;
  end
endmodule

// File: rtl/fsme_addr_gen.sv
module fsme_addr_gen
  import fsme_pkg::*;
#(
  parameter int MBSZ   = 16,
  parameter int NCHUNK = 3,
  parameter int BANKS  = 8,
  parameter int LW     = 6,
  parameter int AW     = 5
) (
  input  logic [LW-1:0]       line,
  input  phase_kind_e         kind,
  output logic [BANKS*AW-1:0] addr_a,
  output logic [BANKS*AW-1:0] addr_b
);
  localparam int MW  = $clog2(MBSZ);
  localparam int RPA = 2 * NCHUNK;

  int chunk;
  always_comb begin
    case (kind)
      PK_LOAD_HI: chunk = 0;
      PK_LOAD_LO: chunk = 1;
      default:    chunk = NCHUNK - 1;
    endcase
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    localparam int W0 = 2 * b;
    localparam int W1 = 2 * b + 1;
    logic [MW-1:0] off0, off1;
    int s0, s1, a0, a1;
    always_comb begin
      off0 = MW'(W0) - line[MW-1:0];
      off1 = MW'(W1) - line[MW-1:0];
      s0   = int'(line) + int'(off0);
      s1   = int'(line) + int'(off1);
      a0   = (s0 / MBSZ) * RPA + chunk * 2;
      a1   = (s1 / MBSZ) * RPA + chunk * 2 + 1;
    end
    assign addr_a[b*AW +: AW] = (kind == PK_IDLE) ? '0 : AW'((a0 < a1) ? a0 : a1);
    assign addr_b[b*AW +: AW] = (kind == PK_IDLE) ? '0 : AW'((a0 < a1) ? a1 : a0);
  end
endmodule

// File: rtl/fsme_best_trk.sv
module fsme_best_trk #(
  parameter int CW = 9,
  parameter int VW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd,
  input  logic          first,
  input  logic [CW-1:0] cost,
  input  logic [VW-1:0] cand_x,
  input  logic [VW-1:0] cand_y,
  output logic [CW-1:0] best_cost,
  output logic [VW-1:0] best_x,
  output logic [VW-1:0] best_y
);
  logic better;
  assign better = first || (cost < best_cost);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      best_cost <= '0;
      best_x    <= '0;
      best_y    <= '0;
    end else if (upd && better) begin
      best_cost <= cost;
      best_x    <= cand_x;
      best_y    <= cand_y;
    end
  end

  AST_COST_MONOTONE: assert property (@(posedge clk) disable iff (!rst_n)
    upd && !first |=> best_cost <= $past(best_cost)); // R8
  AST_FIRST_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    upd && first |=> best_cost == $past(cost)); // R8
endmodule

// File: rtl/fsme_scan_ctrl.sv
module fsme_scan_ctrl
  import fsme_pkg::*;
#(
  parameter int NBLK  = 4,
  parameter int RANGE = 16,
  parameter int MBSZ  = 16,
  localparam int LINES    = 2 * RANGE + 1,
  localparam int STREAM   = LINES - 1,
  localparam int LINE_CYC = STREAM + 2,
  localparam int CW       = $clog2(MBSZ * MBSZ + 1),
  localparam int VW       = $clog2(RANGE + 1) + 1,
  localparam int LW       = $clog2(LINES),
  localparam int PW       = $clog2(LINE_CYC),
  localparam int SW       = $clog2(STREAM),
  localparam int MW       = $clog2(MBSZ),
  localparam int BANKS    = MBSZ / 2,
  localparam int NREG     = (MBSZ + 2 * RANGE + MBSZ - 1) / MBSZ,
  localparam int NCHUNK   = (4 * MBSZ + 2 * RANGE) / (2 * MBSZ),
  localparam int DEPTH    = NREG * 2 * NCHUNK,
  localparam int AW       = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  output logic                 busy,
  output logic                 load_hi,
  output logic                 load_lo,
  output logic                 shift_en,
  output logic [SW-1:0]        bit_sel,
  output logic [MW-1:0]        rot_amt,
  output logic [BANKS*AW-1:0]  rd_addr_a,
  output logic [BANKS*AW-1:0]  rd_addr_b,
  input  logic                 cnt_valid,
  output logic                 cnt_ready,
  input  logic [NBLK*CW-1:0]   cnt_data,
  output logic                 done,
  output logic [NBLK*VW-1:0]   best_dx,
  output logic [NBLK*VW-1:0]   best_dy,
  output logic [NBLK*CW-1:0]   best_cost
);
  logic          active, go, accept, first, last_cand;
  logic [LW-1:0] line, kpos, kline;
  logic [PW-1:0] phase;
  phase_kind_e   kind;
  logic [VW-1:0] cand_x, cand_y;

  assign go = start && !busy && !active;

  fsme_seq #(.LINES(LINES), .LINE_CYC(LINE_CYC), .LW(LW), .PW(PW)) u_seq (
    .clk(clk), .rst_n(rst_n), .go(go), .busy(busy),
    .line(line), .phase(phase), .kind(kind)
  );

  assign load_hi  = (kind == PK_LOAD_HI);
  assign load_lo  = (kind == PK_LOAD_LO);
  assign shift_en = (kind == PK_STREAM);
  assign bit_sel  = shift_en ? SW'(phase - PW'(2)) : '0;
  assign rot_amt  = busy ? line[MW-1:0] : '0;

  fsme_addr_gen #(.MBSZ(MBSZ), .NCHUNK(NCHUNK), .BANKS(BANKS), .LW(LW), .AW(AW)) u_addr (
    .line(line), .kind(kind), .addr_a(rd_addr_a), .addr_b(rd_addr_b)
  );

  // candidate index in scan order
  assign accept    = cnt_valid && active;
  assign first     = (kpos == '0) && (kline == '0);
  assign last_cand = (kpos == LW'(LINES - 1)) && (kline == LW'(LINES - 1));
  assign cand_x    = VW'(RANGE) - VW'(kpos);
  assign cand_y    = VW'(kline) - VW'(RANGE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      kpos   <= '0;
      kline  <= '0;
      done   <= 1'b0;
    end else begin
      done <= accept && last_cand;
      if (go) begin
        active <= 1'b1;
        kpos   <= '0;
        kline  <= '0;
      end else if (accept) begin
        if (kpos == LW'(LINES - 1)) begin
          kpos  <= '0;
          kline <= kline + 1'b1;
        end else begin
          kpos <= kpos + 1'b1;
        end
        if (last_cand) active <= 1'b0;
      end
    end
  end

  assign cnt_ready = active;

  for (genvar i = 0; i < NBLK; i++) begin : g_blk
    fsme_best_trk #(.CW(CW), .VW(VW)) u_trk (
      .clk(clk), .rst_n(rst_n), .upd(accept), .first(first),
      .cost(cnt_data[i*CW +: CW]), .cand_x(cand_x), .cand_y(cand_y),
      .best_cost(best_cost[i*CW +: CW]), .best_x(best_dx[i*VW +: VW]),
      .best_y(best_dy[i*VW +: VW])
    );
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({load_hi, load_lo, shift_en})); // R3
  AST_LOAD_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    load_hi |=> load_lo); // R3
  AST_LOAD_TO_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
    load_lo |=> shift_en && bit_sel == '0); // R3
  AST_ROT_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en && $past(shift_en) |-> $stable(rot_amt)); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_DONE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !cnt_ready); // R6
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_ready && !start |=> $stable(best_cost)); // R9
  for (genvar b = 0; b < BANKS; b++) begin : g_achk
    AST_ADDR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> rd_addr_b[b*AW +: AW] < AW'(DEPTH)
               && rd_addr_a[b*AW +: AW] < rd_addr_b[b*AW +: AW]); // R5
  end
endmodule

// File: tb/sim_fsme_scan_ctrl.sv
module sim_fsme_scan_ctrl;
  localparam int NB = 4, CW = 9, VW = 6, AW = 5, BK = 8, NC = 1089;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, cnt_valid = 1'b0;
  logic [NB*CW-1:0] cnt_data = '0;
  logic busy, load_hi, load_lo, shift_en, cnt_ready, done;
  logic [4:0] bit_sel;
  logic [3:0] rot_amt;
  logic [BK*AW-1:0] rd_addr_a, rd_addr_b;
  logic [NB*VW-1:0] best_dx, best_dy;
  logic [NB*CW-1:0] best_cost;

  always #5 clk = ~clk;

  fsme_scan_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .load_hi(load_hi),
    .load_lo(load_lo), .shift_en(shift_en), .bit_sel(bit_sel), .rot_amt(rot_amt),
    .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b), .cnt_valid(cnt_valid),
    .cnt_ready(cnt_ready), .cnt_data(cnt_data), .done(done), .best_dx(best_dx),
    .best_dy(best_dy), .best_cost(best_cost)
  );

  int checks = 0, errors = 0, cyc = 0, done_seen = 0;

  task automatic chk(input string tag, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", tag, what, got, exp, cyc);
    end
  endtask

  function automatic int cost_of(input int run, input int k, input int blk);
    if (run == 0) return (((k * 73) + (blk * 151) + ((k >> 2) * 29)) ^ (k * 5)) % 257;
    if (run == 1) return 100;
    if (blk < 3) return (256 - k / 4 > 0) ? 256 - k / 4 : 0;
    return k / 5;
  endfunction

  // behavioural reference model
  int m_busy, m_line, m_phase, m_active, m_k, m_done;
  int m_best[NB], m_bx[NB], m_by[NB];

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_busy = 0; m_line = 0; m_phase = 0; m_active = 0; m_k = 0; m_done = 0;
      for (int i = 0; i < NB; i++) begin m_best[i] = 0; m_bx[i] = 0; m_by[i] = 0; end
    end else begin
      automatic bit g = start && !m_busy && !m_active;
      m_done = 0;
      if (g) begin
        m_busy = 1; m_line = 0; m_phase = 0;
      end else if (m_busy) begin
        m_phase++;
        if (m_phase == 34) begin
          m_phase = 0; m_line++;
          if (m_line == 33) begin m_busy = 0; m_line = 0; end
        end
      end
      if (g) begin
        m_active = 1; m_k = 0;
      end else if (m_active && cnt_valid) begin
        for (int i = 0; i < NB; i++) begin
          automatic int c = int'(cnt_data[i*CW +: CW]);
          if (m_k == 0 || c < m_best[i]) begin
            m_best[i] = c; m_bx[i] = 16 - (m_k % 33); m_by[i] = (m_k / 33) - 16;
          end
        end
        m_k++;
        if (m_k == NC) begin m_active = 0; m_done = 1; end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      automatic int chunk, lo[BK], hi[BK];
      chk("R3", "busy", busy, m_busy);
      chk("R3", "load_hi", load_hi, (m_busy && m_phase == 0) ? 1 : 0);
      chk("R3", "load_lo", load_lo, (m_busy && m_phase == 1) ? 1 : 0);
      chk("R3", "shift_en", shift_en, (m_busy && m_phase >= 2) ? 1 : 0);
      chk("R3", "bit_sel", bit_sel, (m_busy && m_phase >= 2) ? m_phase - 2 : 0);
      chk("R4", "rot_amt", rot_amt, m_busy ? m_line % 16 : 0);
      chunk = (m_phase == 0) ? 0 : (m_phase == 1) ? 1 : 2;
      for (int b = 0; b < BK; b++) begin lo[b] = 99; hi[b] = -1; end
      for (int r = 0; r < 16; r++) begin
        automatic int s = m_line + r;
        automatic int bk = (s % 16) / 2;
        automatic int a = (s / 16) * 6 + chunk * 2 + (s % 2);
        if (a < lo[bk]) lo[bk] = a;
        if (a > hi[bk]) hi[bk] = a;
      end
      for (int b = 0; b < BK; b++) begin
        chk("R5", "addr_a", rd_addr_a[b*AW +: AW], m_busy ? lo[b] : 0);
        chk("R5", "addr_b", rd_addr_b[b*AW +: AW], m_busy ? hi[b] : 0);
      end
      chk("R6", "cnt_ready", cnt_ready, m_active);
      chk("R9", "done", done, m_done);
      if (done) done_seen++;
      for (int i = 0; i < NB; i++) begin
        chk("R8", "best_cost", best_cost[i*CW +: CW], m_best[i]);
        chk("R7", "best_dx", best_dx[i*VW +: VW], m_bx[i] & 63);
        chk("R7", "best_dy", best_dy[i*VW +: VW], m_by[i] & 63);
      end
    end
  end

  task automatic pack(input int run, input int k);
    for (int i = 0; i < NB; i++) cnt_data[i*CW +: CW] = CW'(cost_of(run, k, i));
  endtask

  task automatic do_run(input int run);
    automatic int j = 0, t = 0;
    // valid words while not ready must be dropped (R6)
    for (int n = 0; n < 3; n++) begin
      @(negedge clk); cnt_valid = 1'b1; cnt_data = '0;
    end
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R2", "load_hi after start", load_hi, 1);
    done_seen = 0;
    while (j < NC) begin
      automatic bit gap = (run == 0) ? (t % 5 == 2) : (run == 2) ? (t % 3 == 0) : 1'b0;
      t++;
      start = (run == 0 && j == 500) ? 1'b1 : 1'b0;  // ignored while active (R2)
      if (cnt_ready && !gap) begin
        cnt_valid = 1'b1; pack(run, j); j++;
      end else begin
        cnt_valid = gap ? 1'b0 : 1'b1; cnt_data = '0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    cnt_valid = 1'b1; cnt_data = '0;  // junk after the last word (R6)
    while (busy || cnt_ready) @(negedge clk);
    repeat (4) @(negedge clk);
    cnt_valid = 1'b0;
    chk("R9", "done pulses", done_seen, 1);
    for (int i = 0; i < NB; i++) begin
      automatic int bc = 0, bkk = 0;
      for (int k = 0; k < NC; k++) begin
        automatic int c = cost_of(run, k, i);
        if (k == 0 || c < bc) begin bc = c; bkk = k; end
      end
      chk("R8", "final cost", best_cost[i*CW +: CW], bc);
      chk("R7", "final dx", best_dx[i*VW +: VW], (16 - bkk % 33) & 63);
      chk("R7", "final dy", best_dy[i*VW +: VW], (bkk / 33 - 16) & 63);
    end
    if (run == 1) chk("R8", "tie keeps first dx", best_dx[VW-1:0], 16);
    if (run == 2) chk("R7", "late minimum dy", best_dy[VW-1:0], 15);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "reset busy", busy, 0);
    chk("R1", "reset ready", cnt_ready, 0);
    chk("R1", "reset done", done, 0);
    chk("R1", "reset strobes", {load_hi, load_lo, shift_en}, 0);
    chk("R1", "reset cost", best_cost, 0);
    for (int r = 0; r < 3; r++) do_run(r);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule